// File: doc/BRIEF.md
# Four-Channel DMA Request Priority Arbiter

This block sits at the front of a four-channel DMA engine. It decides which channel is served next. Each channel has a hardware request line. A channel's mask bit can block that line, and a software request line can raise a request for the channel regardless of its mask. When any request qualifies, the arbiter asks the processor for the bus. When the processor grants the bus, the arbiter picks one winner and raises that channel's acknowledge. The winner is kept until the transfer logic signals the end of the service, whatever other requests arrive in the meantime.

A mode input selects the priority scheme. The fixed scheme always favours the lowest channel number. The rotating scheme moves the channel just served to the bottom of the order, and the move happens when the bus is handed back. The acknowledge outputs have a programmable polarity, so that they can drive the bus-grant input of a second-level controller. After reset they are active low and idle high.

Top module: `dma_prio_arbiter`

## Requirements
- R1: A channel's request qualifies when its hardware request is high and its mask bit is 0, or when its software request is high. A hardware request with the mask bit set causes no hold request and no acknowledge.
- R2: From the idle state, `hold_req` rises on the first clock edge at which a qualified request is seen. If every qualified request disappears before the bus is granted, `hold_req` falls on the next edge.
- R3: No acknowledge is issued while `bus_grant` is low. The winner is chosen at the first edge where `bus_grant` is sampled high while holding, and its acknowledge, `grant_valid` and `grant_id` are visible after that edge.
- R4: With `rotate_en` = 0, the qualified channel with the lowest number wins (0 highest, 3 lowest).
- R5: With `rotate_en` = 1, the order starts at a top channel and wraps upward. After reset the top channel is 0. When the service of channel k ends, the top channel becomes k+1 (mod 4), so k becomes lowest.
- R6: While a service is active, neither `grant_id` nor the acknowledged channel changes, whatever requests arrive or drop.
- R7: A one-cycle `svc_done` during service removes the acknowledge and drops `hold_req` at the next edge. The arbiter then waits for `bus_grant` to go low before it evaluates new requests.
- R8: After reset the acknowledge polarity is active low, so an idle `chan_ack` is all ones and the winner's bit is 0. A write through `ack_pol_wr` with `ack_pol_val` = 1 makes it active high: idle all zeros, winner's bit 1.
- R9: At most one channel is acknowledged at any time, and it is always the channel named by `grant_id`. `grant_valid` is high exactly during service.
- R10: With all four channels requesting continuously under rotating priority, four successive services visit each channel exactly once, so no channel waits for more than three other services.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_req | input | 4 | Hardware request per channel, active high |
| soft_req | input | 4 | Software request per channel, ignores the mask |
| chan_mask | input | 4 | Per-channel mask, 1 blocks the hardware request |
| rotate_en | input | 1 | 0 = fixed priority, 1 = rotating priority |
| ack_pol_wr | input | 1 | Load strobe for the acknowledge polarity |
| ack_pol_val | input | 1 | Polarity to load: 1 = active high, 0 = active low |
| bus_grant | input | 1 | Bus granted by the processor |
| svc_done | input | 1 | One-cycle pulse at the end of the current service |
| hold_req | output | 1 | Bus request to the processor |
| chan_ack | output | 4 | Per-channel acknowledge, polarity applied |
| grant_valid | output | 1 | High while a channel is being serviced |
| grant_id | output | 2 | Number of the channel being serviced |

## Verification
A wrong rotation pointer cannot be seen until a later service. It shows as the wrong channel acknowledged one cycle after the next bus grant, and only when two or more channels request at once. The bench therefore serves overlapping request patterns after each rotation. A decision that is not frozen shows within one cycle of a competing request arriving mid-service, as a change in `grant_id` or a second active acknowledge. A polarity register with the wrong reset value is visible on `chan_ack` at the first sample after reset.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_SERVE = 2'd2,
    ST_REL   = 2'd3
  } arb_state_t;

endpackage

// File: rtl/arb_req_qual.sv
module arb_req_qual #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] chan_req,
  input  logic [NCH-1:0] soft_req,
  input  logic [NCH-1:0] chan_mask,
  output logic [NCH-1:0] qual,
  output logic           any_qual
);

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_qual
      // hardware line passes only when unmasked; software line always passes
      assign qual[g] = (chan_req[g] & ~chan_mask[g]) | soft_req[g];
    end
  endgenerate

  assign any_qual = |qual;

endmodule

// File: rtl/arb_picker.sv
module arb_picker #(
  parameter int NCH = 4,
  parameter int IDW = 2
) (
  input  logic [NCH-1:0] qual,
  input  logic [IDW-1:0] top,
  input  logic           rotate_en,
  output logic [IDW-1:0] win_id,
  output logic           win_hit
);

  // Scan from the top channel upward with wrap; the entry nearest to top wins.
  function automatic logic [IDW:0] pick_first(input logic [NCH-1:0] q,
                                              input logic [IDW-1:0] t);
    logic [IDW:0] r;
    int unsigned  s;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      s = int'(t) + i;
      if (s >= NCH) s = s - NCH;
      if (q[s]) r = {1'b1, IDW'(s)};
    end
    return r;
  endfunction

  logic [IDW-1:0] eff_top;
  logic [IDW:0]   res;

  assign eff_top = rotate_en ? top : '0;
  assign res     = pick_first(qual, eff_top);
  assign win_hit = res[IDW];
  assign win_id  = res[IDW-1:0];

endmodule

// File: rtl/arb_rot_ptr.sv
module arb_rot_ptr #(
  parameter int NCH = 4,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           advance,
  input  logic [IDW-1:0] served_id,
  output logic [IDW-1:0] top
);

  function automatic logic [IDW-1:0] wrap_next(input logic [IDW-1:0] id);
    return (int'(id) == NCH - 1) ? '0 : id + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       top <= '0;
    else if (advance) top <= wrap_next(served_id);
  end

endmodule

// File: rtl/arb_ack_drive.sv
module arb_ack_drive #(
  parameter int NCH = 4,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pol_wr,
  input  logic           pol_val,
  input  logic           grant_valid,
  input  logic [IDW-1:0] grant_id,
  output logic           pol_q,
  output logic [NCH-1:0] chan_ack
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= 1'b0;
    else if (pol_wr) pol_q <= pol_val;
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ack
      logic sel;
      assign sel         = grant_valid && (grant_id == IDW'(g));
      assign chan_ack[g] = pol_q ? sel : ~sel;
    end
  endgenerate

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_req,
  input  logic [NCH-1:0] soft_req,
  input  logic [NCH-1:0] chan_mask,
  input  logic           rotate_en,
  input  logic           ack_pol_wr,
  input  logic           ack_pol_val,
  input  logic           bus_grant,
  input  logic           svc_done,
  output logic           hold_req,
  output logic [NCH-1:0] chan_ack,
  output logic           grant_valid,
  output logic [IDW-1:0] grant_id
);

  arb_state_t     state, state_nxt;
  logic [NCH-1:0] qual;
  logic           any_qual;
  logic [IDW-1:0] top;
  logic [IDW-1:0] win_id;
  logic           win_hit;
  logic [IDW-1:0] win_q;
  logic           pol_q;
  logic           grant_evt;    // bus granted: decision taken this edge
  logic           release_evt;  // service ends: bus goes back to the processor

  arb_req_qual #(.NCH(NCH)) u_qual (
    .chan_req (chan_req),
    .soft_req (soft_req),
    .chan_mask(chan_mask),
    .qual     (qual),
    .any_qual (any_qual)
  );

  arb_picker #(.NCH(NCH), .IDW(IDW)) u_pick (
    .qual     (qual),
    .top      (top),
    .rotate_en(rotate_en),
    .win_id   (win_id),
    .win_hit  (win_hit)
  );

  assign grant_evt   = (state == ST_HOLD) && win_hit && bus_grant;
  assign release_evt = (state == ST_SERVE) && svc_done;

  arb_rot_ptr #(.NCH(NCH), .IDW(IDW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (release_evt && rotate_en),
    .served_id(win_q),
    .top      (top)
  );

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:  if (any_qual) state_nxt = ST_HOLD;
      ST_HOLD:  if (!any_qual) state_nxt = ST_IDLE;
                else if (grant_evt) state_nxt = ST_SERVE;
      ST_SERVE: if (release_evt) state_nxt = ST_REL;
      ST_REL:   if (!bus_grant) state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      win_q <= '0;
    end else begin
      state <= state_nxt;
      if (grant_evt) win_q <= win_id;
    end
  end

  assign hold_req    = (state == ST_HOLD) || (state == ST_SERVE);
  assign grant_valid = (state == ST_SERVE);
  assign grant_id    = win_q;

  arb_ack_drive #(.NCH(NCH), .IDW(IDW)) u_ack (
    .clk        (clk),
    .rst_n      (rst_n),
    .pol_wr     (ack_pol_wr),
    .pol_val    (ack_pol_val),
    .grant_valid(grant_valid),
    .grant_id   (win_q),
    .pol_q      (pol_q),
    .chan_ack   (chan_ack)
  );

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NCH = 4,
  parameter int IDW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_grant,
  input logic           svc_done,
  input logic           rotate_en,
  input logic [NCH-1:0] qual,
  input logic           hold_req,
  input logic [NCH-1:0] chan_ack,
  input logic           grant_valid,
  input logic [IDW-1:0] grant_id,
  input logic           pol_q
);

  function automatic logic [NCH-1:0] below(input logic [IDW-1:0] id);
    logic [NCH-1:0] m;
    for (int i = 0; i < NCH; i++) m[i] = (i < int'(id));
    return m;
  endfunction

  logic [NCH-1:0] act;
  assign act = pol_q ? chan_ack : ~chan_ack;

  assert_ack_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));

  assert_ack_matches_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> act[grant_id]);

  assert_ack_needs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|act) |-> hold_req);

  assert_ack_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> $past(bus_grant));

  assert_hold_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req) |-> $past(|qual));

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !svc_done) |=> (grant_valid && $stable(grant_id)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && svc_done) |=> (!hold_req && !grant_valid));

  assert_fixed_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grant_valid) && !$past(rotate_en)) |-> (($past(qual) & below(grant_id)) == '0));

  assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (chan_ack == (pol_q ? '0 : '1)));

endmodule

bind dma_prio_arbiter arb_checker #(.NCH(NCH), .IDW(IDW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_grant  (bus_grant),
  .svc_done   (svc_done),
  .rotate_en  (rotate_en),
  .qual       (qual),
  .hold_req   (hold_req),
  .chan_ack   (chan_ack),
  .grant_valid(grant_valid),
  .grant_id   (grant_id),
  .pol_q      (pol_q)
);

// File: tb/sim_dma_prio_arbiter.sv
`timescale 1ns/1ps
module sim_dma_prio_arbiter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] chan_req = '0, soft_req = '0, chan_mask = '0;
  logic       rotate_en = 1'b0, ack_pol_wr = 1'b0, ack_pol_val = 1'b0;
  logic       bus_grant = 1'b0, svc_done = 1'b0;
  logic       hold_req, grant_valid;
  logic [3:0] chan_ack;
  logic [1:0] grant_id;

  int checks = 0;
  int fails  = 0;
  int top_m  = 0;   // bench model of the rotating top channel
  logic pol_m = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dma_prio_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .soft_req(soft_req),
    .chan_mask(chan_mask), .rotate_en(rotate_en), .ack_pol_wr(ack_pol_wr),
    .ack_pol_val(ack_pol_val), .bus_grant(bus_grant), .svc_done(svc_done),
    .hold_req(hold_req), .chan_ack(chan_ack), .grant_valid(grant_valid),
    .grant_id(grant_id)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ack_pattern(input bit valid, input int id, input logic pol);
    logic [3:0] a;
    a = valid ? (4'b1 << id) : 4'b0;
    return pol ? a : ~a;
  endfunction

  // expected winner from the requirements: scan from the top channel upward
  function automatic int expect_win(input logic [3:0] hw, input logic [3:0] sw,
                                    input logic [3:0] msk, input bit rot);
    logic [3:0] q;
    int t;
    q = (hw & ~msk) | sw;
    t = rot ? top_m : 0;
    for (int i = 0; i < 4; i++)
      if (q[(t + i) % 4]) return (t + i) % 4;
    return -1;
  endfunction

  // one full service; an intruding request is raised mid-service
  task automatic do_service(input logic [3:0] hw, input logic [3:0] sw,
                            input logic [3:0] msk, input logic [3:0] intrude,
                            input string tag);
    int exp;
    exp = expect_win(hw, sw, msk, rotate_en);
    @(negedge clk);
    chan_req = hw; soft_req = sw; chan_mask = msk;
    @(negedge clk);
    check(hold_req === 1'b1, {tag, " R2 hold raised"}, hold_req, 1);
    check(chan_ack === ack_pattern(0, 0, pol_m), {tag, " R3 no ack before grant"}, chan_ack, ack_pattern(0, 0, pol_m));
    @(negedge clk);
    check(grant_valid === 1'b0, {tag, " R3 still waiting"}, grant_valid, 0);
    bus_grant = 1'b1;
    @(negedge clk);
    check(grant_valid === 1'b1 && grant_id === exp[1:0], {tag, " R4 R5 R9 winner"}, grant_id, exp);
    check(chan_ack === ack_pattern(1, exp, pol_m), {tag, " R8 ack level"}, chan_ack, ack_pattern(1, exp, pol_m));
    chan_req = hw | intrude; soft_req = sw | intrude; chan_mask = '0;
    @(negedge clk);
    @(negedge clk);
    check(grant_valid === 1'b1 && grant_id === exp[1:0], {tag, " R6 frozen"}, grant_id, exp);
    svc_done = 1'b1;
    @(negedge clk);
    svc_done = 1'b0;
    check(hold_req === 1'b0 && chan_ack === ack_pattern(0, 0, pol_m), {tag, " R7 released"}, chan_ack, ack_pattern(0, 0, pol_m));
    chan_req = '0; soft_req = '0; chan_mask = '0;
    bus_grant = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(hold_req === 1'b0, {tag, " R7 idle after bus return"}, hold_req, 0);
    if (rotate_en) top_m = (exp + 1) % 4;
  endtask

  task automatic t_reset;
    check(hold_req === 1'b0 && grant_valid === 1'b0, "R7 reset idle", hold_req, 0);
    check(chan_ack === 4'hF, "R8 reset active-low idle high", chan_ack, 4'hF);
  endtask

  task automatic t_mask;
    @(negedge clk);
    chan_req = 4'hF; chan_mask = 4'hF;
    repeat (3) @(negedge clk);
    check(hold_req === 1'b0, "R1 masked requests ignored", hold_req, 0);
    check(chan_ack === 4'hF, "R1 no ack on masked", chan_ack, 4'hF);
    chan_req = '0; chan_mask = '0;
    // software request overrides the mask
    do_service(4'h0, 4'b1000, 4'hF, 4'h0, "R1 soft");
    // masked ch0 loses to unmasked ch2
    do_service(4'b0101, 4'h0, 4'b0001, 4'h0, "R1 mask ch0");
  endtask

  task automatic t_drop;
    @(negedge clk);
    soft_req = 4'b0100;
    @(negedge clk);
    check(hold_req === 1'b1, "R2 hold on soft request", hold_req, 1);
    soft_req = '0;
    @(negedge clk);
    check(hold_req === 1'b0, "R2 hold withdrawn", hold_req, 0);
  endtask

  task automatic t_fixed;
    rotate_en = 1'b0;
    do_service(4'b1110, 4'h0, 4'h0, 4'b0001, "R4 fixed a");
    do_service(4'b1100, 4'h0, 4'h0, 4'b0011, "R4 fixed b");
    do_service(4'b1111, 4'h0, 4'h0, 4'h0, "R4 fixed c");
    do_service(4'b1111, 4'h0, 4'h0, 4'h0, "R4 fixed repeat");
  endtask

  task automatic t_rotate;
    rotate_en = 1'b1;
    do_service(4'b0110, 4'h0, 4'h0, 4'b0001, "R5 rot first");
    do_service(4'b1001, 4'h0, 4'h0, 4'h0, "R5 rot after ch1");
    do_service(4'b0011, 4'h0, 4'h0, 4'h0, "R5 rot wrap");
  endtask

  task automatic t_fair;
    logic [3:0] seen;
    seen = '0;
    rotate_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      seen[top_m] = 1'b1;   // model predicts the top channel wins
      do_service(4'hF, 4'h0, 4'h0, 4'h0, "R10 fair");
    end
    check(seen === 4'hF, "R10 every channel served", seen, 4'hF);
  endtask

  task automatic t_polarity;
    @(negedge clk);
    ack_pol_wr = 1'b1; ack_pol_val = 1'b1;
    @(negedge clk);
    ack_pol_wr = 1'b0;
    pol_m = 1'b1;
    check(chan_ack === 4'h0, "R8 active-high idle low", chan_ack, 0);
    rotate_en = 1'b0;
    do_service(4'b0100, 4'h0, 4'h0, 4'b0001, "R8 active high");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_drop();
    t_fixed();
    t_rotate();
    t_fair();
    t_polarity();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule